// File: doc/BRIEF.md
# Pulse-and-Verify Byte Memory Programmer

This controller writes the full contents of a source buffer into a byte-wide, electrically programmable, light-erasable memory. It drives the memory's address, write data, active-low chip-enable and output-enable pins. It also issues two supply-mode requests, one for each supply rail, which an external regulator turns into the raised programming levels. A single `start` pulse launches a run. The run ends with a one-cycle `done` strobe and a sticky `pass` or `fail` flag.

A run has three passes. The blind pass walks from the lowest to the highest address and gives each location a single timed program pulse, with no read-back. The verify pass restarts at address zero and reads each byte at the raised supplies. If the byte does not match, the controller removes the output enable and applies another pulse, then reads again. Each byte may receive at most a fixed number of extra pulses. A byte that still does not match ends the run as a failure. The closing pass returns both supplies to nominal, reads every location in normal read mode and compares it with the buffer.

The pulse width is given in microseconds and turned into clock cycles from the clock-frequency parameter. Each read is taken only after a set number of settle cycles following any change of address, enables or supplies. The source buffer is read through an address output and a byte input that follows that address.

Top module: `prom_burner`

## Requirements
- R1: Out of reset and whenever no run is active, `ceN` and `oeN` are 1, `vppRaise` and `vccRaise` are 0, `done`, `pass` and `fail` are 0 after reset, and `memAddr` is 0 after reset.
- R2: After `start`, exactly one program pulse is applied to every address, in ascending order from 0 to DEPTH-1, before the first verify read.
- R3: Each program pulse holds `ceN` at 0 for exactly PULSE_CYC = (CLK_HZ/1000)*PULSE_US/1000 clock cycles. During the pulse `oeN` is 1 and both supply requests are 1. `memAddr` and `memWrData` stay constant, and `memWrData` equals the source byte of that address.
- R4: A verify read has `ceN`=1, `oeN`=0 and both supply requests at 1. `memRdData` is sampled at the ACCESS_CYC-th rising edge after the last change of address, enables or supplies.
- R5: In the verify pass, a mismatching byte gets `oeN` raised and then one more pulse, and is then read again. A byte may receive up to MAX_TRIES (10) such extra pulses, and the counter is cleared for each new address. A byte that matches after exactly MAX_TRIES extra pulses still leads to pass.
- R6: If a byte still mismatches after MAX_TRIES extra pulses, the run stops at once with `fail`. It applies no further pulses, so later addresses keep only their single blind-pass pulse.
- R7: The closing pass drops both supply requests to 0, reads every address with `ceN`=0 and `oeN`=0, and compares each byte with the source. Any mismatch ends with `fail`. A full match ends with `pass`.
- R8: `done` is high for exactly one cycle per run. Exactly one of `pass` or `fail` is set with it, and that flag holds until the next accepted `start` clears both.
- R9: A `start` pulse that arrives while a run is active has no effect on the run: the pulse counts, the result and the number of `done` strobes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run (accepted only when idle) |
| memAddr | output | ADDR_W | Address to the target memory |
| memWrData | output | 8 | Byte to program |
| memRdData | input | 8 | Byte read back from the target memory |
| ceN | output | 1 | Chip enable, active low; the program pulse |
| oeN | output | 1 | Output enable, active low |
| vppRaise | output | 1 | Request for the raised programming rail |
| vccRaise | output | 1 | Request for the raised core rail |
| srcAddr | output | ADDR_W | Address into the source buffer |
| srcData | input | 8 | Source byte at `srcAddr` |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Sticky success flag |
| fail | output | 1 | Sticky failure flag |

## Verification
The bench builds the block with DEPTH=16, CLK_HZ=100000 (10-cycle pulses) and ACCESS_CYC=3. This makes every address, every pulse edge and every read window small enough to check one by one. The bench's memory model sets how many pulses each address needs. With that, it can place a byte exactly at the ten-retry limit and one byte just past it, plus a byte that only fails at nominal supplies. The model returns corrupted data for reads taken before the settle window ends, so a controller that samples early cannot match.

// File: rtl/prom_burner_pkg.sv
package prom_burner_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_P1_SETUP,
    S_P1_PULSE,
    S_VERIFY,
    S_REGAP,
    S_P2_PULSE,
    S_FINAL
  } burnState_t;

  // strobes and levels from the control FSM to the datapath
  typedef struct packed {
    logic addrClr;
    logic addrInc;
    logic latchData;
    logic tryClr;
    logic tryInc;
    logic ceLow;
    logic oeLow;
    logic suppRaise;
    logic setPass;
    logic setFail;
    logic clrResult;
    logic doneStb;
  } burnCtl_t;

  // status from the datapath back to the FSM
  typedef struct packed {
    logic lastAddr;
    logic tryMax;
    logic match;
  } burnStat_t;

endpackage

// File: rtl/prom_burner_ctl.sv
module prom_burner_ctl
  import prom_burner_pkg::*;
#(
  parameter int PULSE_CYC  = 12500,
  parameter int ACCESS_CYC = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  burnStat_t stat,
  output burnCtl_t  ctl
);

  localparam int WAIT_MAX = (PULSE_CYC > ACCESS_CYC) ? PULSE_CYC : ACCESS_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  burnState_t state, nextState;
  logic [WAIT_W-1:0] waitCnt;
  logic waitDone, inPulse, restartWait;

  assign inPulse  = (state == S_P1_PULSE) || (state == S_P2_PULSE);
  assign waitDone = inPulse ? (waitCnt == WAIT_W'(PULSE_CYC - 1))
                            : (waitCnt == WAIT_W'(ACCESS_CYC - 1));
  // any change of address or outputs restarts the settle/pulse timer
  assign restartWait = (nextState != state) || ctl.addrInc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      state <= nextState;
      if (restartWait)   waitCnt <= '0;
      else if (!waitDone) waitCnt <= waitCnt + 1'b1;
    end
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.addrClr   = 1'b1;
          ctl.tryClr    = 1'b1;
          ctl.clrResult = 1'b1;
          nextState     = S_P1_SETUP;
        end
      end
      S_P1_SETUP: begin
        ctl.suppRaise = 1'b1;
        ctl.latchData = 1'b1;
        if (waitDone) nextState = S_P1_PULSE;
      end
      S_P1_PULSE: begin
        ctl.suppRaise = 1'b1;
        ctl.ceLow     = 1'b1;
        if (waitDone) begin
          if (stat.lastAddr) begin
            ctl.addrClr = 1'b1;
            ctl.tryClr  = 1'b1;
            nextState   = S_VERIFY;
          end else begin
            ctl.addrInc = 1'b1;
            nextState   = S_P1_SETUP;
          end
        end
      end
      S_VERIFY: begin
        ctl.suppRaise = 1'b1;
        ctl.oeLow     = 1'b1;
        if (waitDone) begin
          if (stat.match) begin
            if (stat.lastAddr) begin
              ctl.addrClr = 1'b1;
              nextState   = S_FINAL;
            end else begin
              ctl.addrInc = 1'b1;
              ctl.tryClr  = 1'b1;
            end
          end else if (stat.tryMax) begin
            ctl.setFail = 1'b1;
            ctl.doneStb = 1'b1;
            nextState   = S_IDLE;
          end else begin
            nextState = S_REGAP;
          end
        end
      end
      S_REGAP: begin
        ctl.suppRaise = 1'b1;
        ctl.latchData = 1'b1;
        if (waitDone) begin
          ctl.tryInc = 1'b1;
          nextState  = S_P2_PULSE;
        end
      end
      S_P2_PULSE: begin
        ctl.suppRaise = 1'b1;
        ctl.ceLow     = 1'b1;
        if (waitDone) nextState = S_VERIFY;
      end
      S_FINAL: begin
        ctl.ceLow = 1'b1;
        ctl.oeLow = 1'b1;
        if (waitDone) begin
          if (!stat.match) begin
            ctl.setFail = 1'b1;
            ctl.doneStb = 1'b1;
            nextState   = S_IDLE;
          end else if (stat.lastAddr) begin
            ctl.setPass = 1'b1;
            ctl.doneStb = 1'b1;
            nextState   = S_IDLE;
          end else begin
            ctl.addrInc = 1'b1;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R4 / R3: the timer never runs past its longest window
  p_wait_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt < WAIT_W'(WAIT_MAX));

  // R9: a busy machine never jumps back into the blind pass
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && state != S_P1_SETUP && state != S_P1_PULSE)
      |=> (state != S_P1_SETUP));

endmodule

// File: rtl/prom_burner_dp.sv
module prom_burner_dp
  import prom_burner_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 4,
  parameter int MAX_TRIES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  burnCtl_t          ctl,
  input  logic [7:0]        memRdData,
  input  logic [7:0]        srcData,
  output burnStat_t         stat,
  output logic [ADDR_W-1:0] addrQ,
  output logic [7:0]        wrDataQ,
  output logic              ceN,
  output logic              oeN,
  output logic              vppRaise,
  output logic              vccRaise,
  output logic              doneQ,
  output logic              passQ,
  output logic              failQ
);

  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [TRY_W-1:0] tryQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrDataQ <= '0;
      tryQ    <= '0;
      doneQ   <= 1'b0;
      passQ   <= 1'b0;
      failQ   <= 1'b0;
    end else begin
      if (ctl.addrClr)      addrQ <= '0;
      else if (ctl.addrInc) addrQ <= addrQ + 1'b1;

      if (ctl.latchData) wrDataQ <= srcData;

      if (ctl.tryClr)      tryQ <= '0;
      else if (ctl.tryInc) tryQ <= tryQ + 1'b1;

      if (ctl.clrResult) begin
        passQ <= 1'b0;
        failQ <= 1'b0;
      end else begin
        if (ctl.setPass) passQ <= 1'b1;
        if (ctl.setFail) failQ <= 1'b1;
      end
      doneQ <= ctl.doneStb;
    end
  end

  assign ceN      = ~ctl.ceLow;
  assign oeN      = ~ctl.oeLow;
  assign vppRaise = ctl.suppRaise;
  assign vccRaise = ctl.suppRaise;

  assign stat.lastAddr = (addrQ == LAST_ADDR);
  assign stat.tryMax   = (tryQ == TRY_W'(MAX_TRIES));
  assign stat.match    = (memRdData == srcData);

  // R3: the memory output is off during any program pulse
  p_pulse_oe_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && vppRaise) |-> oeN);

  // R3: address and data hold still across a pulse
  p_pulse_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && vppRaise && $past(!ceN && vppRaise))
      |-> ($stable(addrQ) && $stable(wrDataQ)));

  // R5: the extra-pulse counter never passes its cap
  p_try_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    tryQ <= TRY_W'(MAX_TRIES));

  // R7: closing reads happen at nominal supplies only
  p_final_nominal_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN) |-> (!vppRaise && !vccRaise));

  // R8: result flags are exclusive and done is a single-cycle strobe
  p_result_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(passQ && failQ));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  p_done_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (passQ ^ failQ));

  // R1: once done fires the pins are back in their quiet state
  p_idle_after_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (ceN && oeN && !vppRaise));

endmodule

// File: rtl/prom_burner.sv
module prom_burner
  import prom_burner_pkg::*;
#(
  parameter int DEPTH      = 524288,
  parameter int ADDR_W     = $clog2(DEPTH),
  parameter int CLK_HZ     = 125000000,
  parameter int PULSE_US   = 100,
  parameter int ACCESS_CYC = 16,
  parameter int MAX_TRIES  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  output logic              ceN,
  output logic              oeN,
  output logic              vppRaise,
  output logic              vccRaise,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic [7:0]        srcData,
  output logic              done,
  output logic              pass,
  output logic              fail
);

  localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;

  burnCtl_t  ctl;
  burnStat_t stat;
  logic [ADDR_W-1:0] addrQ;

  prom_burner_ctl #(
    .PULSE_CYC (PULSE_CYC),
    .ACCESS_CYC(ACCESS_CYC)
  ) u_ctl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stat (stat),
    .ctl  (ctl)
  );

  prom_burner_dp #(
    .DEPTH    (DEPTH),
    .ADDR_W   (ADDR_W),
    .MAX_TRIES(MAX_TRIES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memRdData(memRdData),
    .srcData  (srcData),
    .stat     (stat),
    .addrQ    (addrQ),
    .wrDataQ  (memWrData),
    .ceN      (ceN),
    .oeN      (oeN),
    .vppRaise (vppRaise),
    .vccRaise (vccRaise),
    .doneQ    (done),
    .passQ    (pass),
    .failQ    (fail)
  );

  assign memAddr = addrQ;
  assign srcAddr = addrQ;

endmodule

// File: tb/prom_burner_test.sv
module prom_burner_test;

  localparam int DEPTH  = 16;
  localparam int AW     = 4;
  localparam int CLK_HZ = 100000;
  localparam int PUS    = 100;
  localparam int ACC    = 3;
  localparam int TRIES  = 10;
  localparam int PCYC   = (CLK_HZ / 1000) * PUS / 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] memAddr, srcAddr;
  logic [7:0] memWrData, srcData;
  logic [7:0] memRdData = 8'h00;
  logic ceN, oeN, vppRaise, vccRaise, done, pass, fail;

  always #4 clk = ~clk;

  prom_burner #(
    .DEPTH(DEPTH), .ADDR_W(AW), .CLK_HZ(CLK_HZ), .PULSE_US(PUS),
    .ACCESS_CYC(ACC), .MAX_TRIES(TRIES)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData),
    .ceN(ceN), .oeN(oeN), .vppRaise(vppRaise), .vccRaise(vccRaise),
    .srcAddr(srcAddr), .srcData(srcData),
    .done(done), .pass(pass), .fail(fail)
  );

  function automatic logic [7:0] srcByte(input int a);
    return 8'((a * 37 + 11) & 8'h7F);   // never 8'hFF
  endfunction

  assign srcData = srcByte(int'(srcAddr));

  int nChk = 0;
  int nFail = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  int pulses [DEPTH];
  int need   [DEPTH];
  int weakAddr = -1;
  int age = 0;
  logic [AW+3:0] key, lastKey = '0;
  int lowCnt = 0;
  logic [AW-1:0] pAddr = '0;
  logic [7:0] pData = '0;
  int p1Next = 0, p1AtVerify = 0;
  bit verifySeen = 1'b0;
  int stabBad = 0, widthBad = 0, oeBad = 0, dataBad = 0, orderBad = 0, supplyBad = 0;
  int doneCnt = 0, doneLong = 0;
  logic prevDone = 1'b0;
  int ra;

  always @(negedge clk) begin
    key = {memAddr, ceN, oeN, vppRaise, vccRaise};
    if (key !== lastKey) age = 0;
    else if (age < 1000) age++;
    lastKey = key;

    if (!ceN && vppRaise) begin
      if (lowCnt == 0) begin
        pAddr = memAddr;
        pData = memWrData;
      end else if (memAddr !== pAddr || memWrData !== pData) stabBad++;
      if (!oeN) oeBad++;
      lowCnt++;
    end else if (lowCnt > 0) begin
      if (lowCnt != PCYC) widthBad++;
      if (pData !== srcByte(int'(pAddr))) dataBad++;
      pulses[pAddr]++;
      if (!verifySeen) begin
        if (int'(pAddr) != p1Next) orderBad++;
        p1Next++;
      end
      lowCnt = 0;
    end

    if (!oeN && ceN) begin
      if (!verifySeen) begin
        verifySeen = 1'b1;
        p1AtVerify = p1Next;
      end
      if (!vppRaise || !vccRaise) supplyBad++;
    end
    if (!oeN && !ceN && (vppRaise || vccRaise)) supplyBad++;

    if (done) begin
      doneCnt++;
      if (prevDone) doneLong++;
    end
    prevDone = done;

    ra = int'(memAddr);
    if (oeN)                              memRdData = 8'h00;
    else if (age < ACC - 1)               memRdData = srcByte(ra) ^ 8'h3C;
    else if (pulses[ra] < need[ra])       memRdData = 8'hFF;
    else if (!vppRaise && ra == weakAddr) memRdData = srcByte(ra) ^ 8'h01;
    else                                  memRdData = srcByte(ra);
  end

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // mode 0: one pulse each; 1: 1..11 pulses; 2: two pulses each
  task automatic runCase(input string tag, input int mode, input int stuckA,
                         input int weakA, input bit poke, input bit expPass);
    int expN;
    string rq;
    for (int a = 0; a < DEPTH; a++) begin
      pulses[a] = 0;
      need[a] = (mode == 0) ? 1 : (mode == 1) ? 1 + ((a * 7) % 11) : 2;
      if (a == stuckA) need[a] = TRIES + 2;
    end
    weakAddr = weakA;
    stabBad = 0; widthBad = 0; oeBad = 0; dataBad = 0; orderBad = 0; supplyBad = 0;
    doneCnt = 0; doneLong = 0; verifySeen = 1'b0; p1Next = 0; p1AtVerify = 0;

    pulseStart();
    if (poke) begin
      repeat (40) @(negedge clk);
      pulseStart();            // R9: during blind pass
      repeat (250) @(negedge clk);
      pulseStart();            // R9: during verify pass
    end
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);

    $display("case %s", tag);
    chk("R8", "pass flag", int'(pass), int'(expPass));
    chk("R8", "fail flag", int'(fail), int'(!expPass));
    chk("R8", "done strobes", doneCnt, 1);
    chk("R8", "done longer than a cycle", doneLong, 0);
    chk("R1", "idle pins", int'({ceN, oeN, vppRaise, vccRaise}), 4'b1100);
    chk("R3", "pulse width errors", widthBad, 0);
    chk("R3", "pulse stability errors", stabBad, 0);
    chk("R3", "pulse with oe low", oeBad, 0);
    chk("R3", "pulse data errors", dataBad, 0);
    chk("R2", "blind pass order errors", orderBad, 0);
    chk("R2", "pulses before first verify", p1AtVerify, DEPTH);
    chk("R4", "supply level errors on reads (R7)", supplyBad, 0);
    rq = (stuckA >= 0) ? "R6" : (poke ? "R9" : "R5");
    for (int a = 0; a < DEPTH; a++) begin
      if (stuckA >= 0 && a > stuckA) expN = 1;
      else if (a == stuckA)          expN = 1 + TRIES;
      else                           expN = need[a];
      chk(rq, $sformatf("pulses at %0d", a), pulses[a], expN);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      pulses[a] = 0;
      need[a] = 1;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ceN", int'(ceN), 1);
    chk("R1", "oeN", int'(oeN), 1);
    chk("R1", "supplies", int'({vppRaise, vccRaise}), 0);
    chk("R1", "done/pass/fail", int'({done, pass, fail}), 0);
    chk("R1", "address", int'(memAddr), 0);

    runCase("single pulse each", 0, -1, -1, 1'b0, 1'b1);
    runCase("retry cap exceeded", 1, 5, -1, 1'b0, 1'b0);   // R6
    runCase("up to ten retries", 1, -1, -1, 1'b0, 1'b1);   // R5, clears old fail
    runCase("nominal read fault", 0, -1, 9, 1'b0, 1'b0);   // R7
    runCase("start while busy", 2, -1, -1, 1'b1, 1'b1);    // R9

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule